// File: doc/BRIEF.md
# Display Frame Base Flip Controller

This block keeps the start address of the picture a display controller scans out. Software may write a new start address whenever it likes. The value goes into a shadow register and is marked as pending. The scan-out logic keeps reading the active register, which changes only when the timing generator pulses `frame_start_i`. On that pulse the pending shadow value moves to the active register, and a "flip done" status bit is set. Software can wait on that bit to learn that the old buffer is free. The result is a page flip that never tears, with a completion event.

A small register port gives access to the shadow base, the active base, an interrupt enable mask, the raw status, the masked status and a write-one-to-clear register. There are two interrupt sources:

- Source 0 reports that a flip was taken into use.
- Source 1 reports each frame boundary.

`irq_o` is the OR of the enabled status bits. It stays high until software clears those bits.

Top module: `flip_base_ctrl`

## Requirements
- R1: After reset, the shadow base, active base, enable mask and raw status all read zero, and `irq_o` is low.
- R2: Writing the shadow base (register index 0) stores the value with its two lowest bits forced to zero. The active base output never has those bits set.
- R3: A shadow write leaves `active_base_o` unchanged until a `frame_start_i` pulse. At that pulse a pending value becomes the active base in the same clock edge.
- R4: A `frame_start_i` pulse with no pending write leaves the active base unchanged and does not set status bit 0. Every pulse sets status bit 1.
- R5: When several shadow writes occur between two frame pulses, only the last value is transferred, and only one bit-0 event results.
- R6: A shadow write in the same cycle as `frame_start_i` is held for the following pulse. The value that was pending before that write is the one transferred at the pulse.
- R7: The raw status (index 3) shows the unmasked status bits. The masked status (index 4) equals the raw status ANDed with the enable mask (index 2).
- R8: `irq_o` is high exactly when the masked status is non-zero, and it stays high until the bits are cleared. An all-zero enable mask keeps `irq_o` low.
- R9: Writing the clear register (index 5) clears exactly the status bits written as one and leaves the others set.
- R10: When a status bit is set and cleared in the same cycle, it ends up set.
- R11: Reads return data one cycle after the read index is presented. Writes to the active base (index 1) and to the raw or masked status (indices 3, 4) have no effect. The clear register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | One-cycle frame boundary pulse from the timing generator |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Register write index |
| reg_wdata_i | input | DW | Register write data |
| reg_raddr_i | input | 3 | Register read index |
| reg_rdata_o | output | DW | Registered read data, one cycle after the index |
| active_base_o | output | DW | Base address currently used for scan-out |
| irq_o | output | 1 | Registered interrupt, OR of the masked status |

## Verification
The bench builds the block with the default 32-bit data width. This lets it write base values that use the top address bit, and values whose two low bits are set, so the alignment rule shows at full width. The two-source status vector lets the tests show that the two sources are masked, cleared and re-set independently. That includes a write in the same cycle as the frame pulse, and a clear that collides with a new set.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int NSRC    = 2;
  localparam int SRC_UPD = 0;
  localparam int SRC_FRM = 1;
  localparam int RIDX_W  = 3;

  typedef enum logic [RIDX_W-1:0] {
    RI_SHADOW = 3'd0,
    RI_ACTIVE = 3'd1,
    RI_ENABLE = 3'd2,
    RI_RAW    = 3'd3,
    RI_MASKED = 3'd4,
    RI_CLEAR  = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/fbf_wdec.sv
module fbf_wdec
  import fbf_pkg::*;
(
  input  logic              wr_i,
  input  logic [RIDX_W-1:0] waddr_i,
  output logic              base_wr_o,
  output logic              en_wr_o,
  output logic              clr_wr_o
);
  always_comb begin
    base_wr_o = 1'b0;
    en_wr_o   = 1'b0;
    clr_wr_o  = 1'b0;
    if (wr_i) begin
      unique case (waddr_i)
        RI_SHADOW: base_wr_o = 1'b1;
        RI_ENABLE: en_wr_o   = 1'b1;
        RI_CLEAR:  clr_wr_o  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/fbf_base_shadow.sv
module fbf_base_shadow #(
  parameter int DW         = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          frame_start_i,
  output logic [DW-1:0] shadow_o,
  output logic [DW-1:0] active_o,
  output logic          update_o
);
  logic [DW-1:0] shadow_q, active_q;
  logic          pending_q;

  always_comb update_o = pending_q & frame_start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (wr_i)     shadow_q <= {wdata_i[DW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (update_o) active_q <= shadow_q;
      if (wr_i)          pending_q <= 1'b1;
      else if (update_o) pending_q <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/fbf_irq_ctrl.sv
module fbf_irq_ctrl #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set_i,
  input  logic          en_wr_i,
  input  logic [NS-1:0] en_wdata_i,
  input  logic          clr_wr_i,
  input  logic [NS-1:0] clr_bits_i,
  output logic [NS-1:0] raw_o,
  output logic [NS-1:0] en_o,
  output logic [NS-1:0] masked_o,
  output logic          irq_o
);
  logic [NS-1:0] raw_q, raw_d, en_q, en_d;
  logic          irq_q;

  for (genvar g = 0; g < NS; g++) begin : g_src
    always_comb raw_d[g] = set_i[g] | (raw_q[g] & ~(clr_wr_i & clr_bits_i[g]));
  end

  always_comb en_d = en_wr_i ? en_wdata_i : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
      irq_q <= |(raw_d & en_d);
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/fbf_rd_mux.sv
module fbf_rd_mux
  import fbf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] raddr_i,
  input  logic [DW-1:0]     shadow_i,
  input  logic [DW-1:0]     active_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   raw_i,
  input  logic [NSRC-1:0]   masked_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (raddr_i)
      RI_SHADOW: sel = shadow_i;
      RI_ACTIVE: sel = active_i;
      RI_ENABLE: sel[NSRC-1:0] = en_i;
      RI_RAW:    sel[NSRC-1:0] = raw_i;
      RI_MASKED: sel[NSRC-1:0] = masked_i;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel;
  end
endmodule

// File: rtl/flip_base_ctrl.sv
module flip_base_ctrl
  import fbf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  input  logic              reg_wr_i,
  input  logic [RIDX_W-1:0] reg_waddr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [RIDX_W-1:0] reg_raddr_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [DW-1:0]     active_base_o,
  output logic              irq_o
);
  localparam int ALIGN_BITS = 2;

  logic            base_wr, en_wr, clr_wr, upd_evt;
  logic [DW-1:0]   shadow_base;
  logic [NSRC-1:0] set_vec, raw_st, en_st, masked_st;

  fbf_wdec u_wdec (
    .wr_i(reg_wr_i), .waddr_i(reg_waddr_i),
    .base_wr_o(base_wr), .en_wr_o(en_wr), .clr_wr_o(clr_wr)
  );

  fbf_base_shadow #(.DW(DW), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk(clk), .rst(rst), .wr_i(base_wr), .wdata_i(reg_wdata_i),
    .frame_start_i(frame_start_i), .shadow_o(shadow_base),
    .active_o(active_base_o), .update_o(upd_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_UPD] = upd_evt;
    set_vec[SRC_FRM] = frame_start_i;
  end

  fbf_irq_ctrl #(.NS(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set_i(set_vec),
    .en_wr_i(en_wr), .en_wdata_i(reg_wdata_i[NSRC-1:0]),
    .clr_wr_i(clr_wr), .clr_bits_i(reg_wdata_i[NSRC-1:0]),
    .raw_o(raw_st), .en_o(en_st), .masked_o(masked_st), .irq_o(irq_o)
  );

  fbf_rd_mux #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .raddr_i(reg_raddr_i),
    .shadow_i(shadow_base), .active_i(active_base_o),
    .en_i(en_st), .raw_i(raw_st), .masked_i(masked_st),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker
  import fbf_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start_i,
  input logic              reg_wr_i,
  input logic [RIDX_W-1:0] reg_waddr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [DW-1:0]     active_base_o,
  input logic              irq_o,
  input logic              upd,
  input logic [NSRC-1:0]   raw,
  input logic [NSRC-1:0]   en
);
  logic base_w, clr_w;
  assign base_w = reg_wr_i && (reg_waddr_i == RI_SHADOW);
  assign clr_w  = reg_wr_i && (reg_waddr_i == RI_CLEAR);

  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    active_base_o[1:0] == 2'b00);

  p_hold_until_frame_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_start_i |=> $stable(active_base_o));

  p_single_event_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && !base_w) |=> !upd);

  p_irq_is_or_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw & en));

  p_mask_off_r8: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> !irq_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (upd && clr_w && reg_wdata_i[SRC_UPD]) |=> raw[SRC_UPD]);
endmodule

bind flip_base_ctrl fbf_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .frame_start_i(frame_start_i),
  .reg_wr_i(reg_wr_i), .reg_waddr_i(reg_waddr_i), .reg_wdata_i(reg_wdata_i),
  .active_base_o(active_base_o), .irq_o(irq_o),
  .upd(upd_evt), .raw(raw_st), .en(en_st)
);

// File: tb/flip_base_ctrl_tb_top.sv
module flip_base_ctrl_tb_top;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fs = 1'b0;
  logic          wr = 1'b0;
  logic [2:0]    waddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]    raddr = '0;
  logic [DW-1:0] rdata, active;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flip_base_ctrl #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .frame_start_i(fs),
    .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .active_base_o(active), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one clock with the given stimulus, inputs idle again at the next falling edge
  task automatic cyc(input logic f, input logic w, input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    fs = f; wr = w; waddr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    fs = 0; wr = 0; waddr = '0; wdata = '0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic frame();
    cyc(1'b1, 1'b0, 3'd0, '0);
  endtask

  task automatic rreg(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    raddr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rreg(3'd0, v); check("R1 shadow", v, 0);
    rreg(3'd1, v); check("R1 active", v, 0);
    rreg(3'd2, v); check("R1 enable", v, 0);
    rreg(3'd3, v); check("R1 raw", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 active port", active, 0);
  endtask

  task automatic t_align_defer();
    logic [DW-1:0] v;
    wreg(3'd0, 32'h9234_5677);
    rreg(3'd0, v); check("R2 shadow aligned", v, 32'h9234_5674);
    repeat (3) @(negedge clk);
    check("R3 active held before frame", active, 0);
    frame();
    check("R3 active after frame", active, 32'h9234_5674);
    rreg(3'd3, v); check("R3 raw after flip", v, 3);
    wreg(3'd5, 3);
  endtask

  task automatic t_idle_frame();
    logic [DW-1:0] v;
    frame();
    check("R4 active unchanged", active, 32'h9234_5674);
    rreg(3'd3, v); check("R4 only frame bit", v, 2);
    wreg(3'd5, 3);
  endtask

  task automatic t_double_write();
    logic [DW-1:0] v;
    wreg(3'd0, 32'h0000_1000);
    wreg(3'd0, 32'h0000_2003);
    frame();
    check("R5 last value wins", active, 32'h0000_2000);
    rreg(3'd3, v); check("R5 event raised", v, 3);
    wreg(3'd5, 3);
    frame();
    rreg(3'd3, v); check("R5 no second event", v, 2);
    wreg(3'd5, 3);
  endtask

  task automatic t_coincide();
    logic [DW-1:0] v;
    wreg(3'd0, 32'h0000_3000);
    cyc(1'b1, 1'b1, 3'd0, 32'h0000_4000);
    check("R6 older pending transferred", active, 32'h0000_3000);
    rreg(3'd0, v); check("R6 shadow holds new", v, 32'h0000_4000);
    wreg(3'd5, 3);
    frame();
    check("R6 new value at next frame", active, 32'h0000_4000);
    rreg(3'd3, v); check("R6 event at next frame", v, 3);
    wreg(3'd5, 3);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    wreg(3'd0, 32'h0000_5000);
    frame();
    rreg(3'd3, v); check("R7 raw unmasked", v, 3);
    rreg(3'd4, v); check("R7 masked zero", v, 0);
    check("R8 irq low with mask zero", {31'd0, irq}, 0);
    wreg(3'd2, 1);
    rreg(3'd4, v); check("R7 masked = raw & en", v, 1);
    check("R8 irq high", {31'd0, irq}, 1);
  endtask

  task automatic t_hold_clear();
    logic [DW-1:0] v;
    repeat (5) @(negedge clk);
    check("R8 irq held", {31'd0, irq}, 1);
    wreg(3'd5, 2);
    rreg(3'd3, v); check("R9 only bit1 cleared", v, 1);
    check("R8 irq still high", {31'd0, irq}, 1);
    wreg(3'd5, 1);
    rreg(3'd3, v); check("R9 bit0 cleared", v, 0);
    check("R8 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    wreg(3'd0, 32'h0000_6000);
    cyc(1'b1, 1'b1, 3'd5, 3);
    rreg(3'd3, v); check("R10 set wins over clear", v, 3);
    check("R10 irq", {31'd0, irq}, 1);
    wreg(3'd5, 3);
  endtask

  task automatic t_readonly();
    logic [DW-1:0] v;
    wreg(3'd1, 32'h0000_ABC0);
    check("R11 active not writable", active, 32'h0000_6000);
    wreg(3'd3, 3);
    rreg(3'd3, v); check("R11 raw not writable", v, 0);
    rreg(3'd5, v); check("R11 clear reads zero", v, 0);
    @(negedge clk); raddr = 3'd0;
    @(posedge clk); @(negedge clk);
    raddr = 3'd1;
    check("R11 old index data", rdata, 32'h0000_6000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_align_defer();
    t_idle_frame();
    t_double_write();
    t_coincide();
    t_mask();
    t_hold_clear();
    t_set_wins();
    t_readonly();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule